// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Refresh

This block is a watchdog for a small microcontroller. It runs on the machine-cycle clock. A 15-bit up-counter is split into a 7-bit upper part and an 8-bit lower part. A prescaler advances the counter, and software chooses its division ratio. Software fills an 8-bit reload register and then sets the start bit. From that point the watchdog keeps running until an external hardware reset.

While running, software must refresh the watchdog before the counter reaches 7FFCh. A refresh takes two steps. Software first sets the arm bit, which clears itself after a short window. Software then sets the start bit within that window. If the counter gets to 7FFCh, the block drives an internal reset for the final four counts and records the event in a status flag. The watchdog keeps running after its own reset.

Idle and power-down indications freeze the counter and the prescaler. The counter registers cannot be read or written by software.

Top module: `watchdog_unit`

## Requirements
- R1: After the external reset (rst_ni low), run_o, arm_o, flag_o and wdt_rst_o are all 0. The counter does not advance until the start bit is set, so wdt_rst_o stays 0.
- R2: Setting the start bit while stopped does three things: it sets run_o, it loads the counter with {reload[6:0], 8'h00}, and it clears the prescaler. wdt_rst_o then rises (7FFCh − load) × D cycles after the load edge. D is 2 when reload bit 7 was 0 at load time and 32 when it was 1.
- R3: Once running, the watchdog cannot be stopped by software. A start-bit write made while running with arm_o at 0 has no effect on the timeout.
- R4: A start-bit write sampled 1 or 2 cycles after the arm write reloads the counter as in R2. Arming is sampled at edge a; the start write counts if sampled at edge a+1 or a+2.
- R5: arm_o is 1 for the two cycles after arming and returns to 0 at the third edge. A start-bit write sampled at edge a+3 or later does not reload.
- R6: A reload-register write, including the prescaler select in bit 7, takes effect only at the next start or refresh.
- R7: wdt_rst_o is high while the count is 7FFCh to 7FFFh. That is 8 cycles with D=2 and 128 cycles with D=32. The counter then wraps to 0 and continues.
- R8: Reaching 7FFCh sets flag_o, and run_o stays 1. A flag_clr_i pulse clears flag_o. A set in the same cycle wins over the clear.
- R9: While idle_i or pdown_i is high, the counter and the prescaler hold their values. Counting resumes when both are low, so the timeout is delayed by exactly the frozen cycles.
- R10: rst_ni low clears run_o and flag_o at any time, including after a watchdog reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Machine-cycle clock |
| rst_ni | input | 1 | External hardware reset, asynchronous, active low |
| reload_we_i | input | 1 | Write strobe for the reload register |
| reload_i | input | 8 | Reload data: bit 7 selects the prescaler, bits 6..0 hold the upper counter value |
| arm_set_i | input | 1 | Software sets the arm bit |
| start_set_i | input | 1 | Software sets the start bit |
| flag_clr_i | input | 1 | Software clears the status flag |
| idle_i | input | 1 | Idle mode indication, freezes counting |
| pdown_i | input | 1 | Power-down indication, freezes counting |
| wdt_rst_o | output | 1 | Internal reset request |
| flag_o | output | 1 | Watchdog reset status flag |
| run_o | output | 1 | Watchdog running |
| arm_o | output | 1 | Arm bit, self-clearing |

## Verification
The following are checked on every cycle:
- the running state never falls once set;
- the arm window never exceeds its length;
- a frozen or untimed cycle leaves the prescaler and the counter unchanged;
- entering 7FFCh raises the reset, and every rising reset comes with the flag set.

Other behaviour needs the bench's scenarios, because it depends on elapsed time:
- the exact timeout length for several reload values under both prescaler settings;
- the pulse widths of 8 and 128 cycles;
- the refresh-versus-ignore decision for each start delay after arming;
- the deferred effect of reload writes;
- the extension of the timeout by a freeze.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {PSC_FAST = 1'b0, PSC_SLOW = 1'b1} psc_sel_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 32
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     en_i,
  input  psc_sel_e sel_i,
  output logic     tick_o
);
  localparam int PW = $clog2(SLOW_DIV);
  localparam logic [PW-1:0] FAST_LAST = PW'(FAST_DIV - 1);
  localparam logic [PW-1:0] SLOW_LAST = PW'(SLOW_DIV - 1);

  logic [PW-1:0] psc_q;
  logic [PW-1:0] last;

  assign last   = (sel_i == PSC_SLOW) ? SLOW_LAST : FAST_LAST;
  assign tick_o = en_i && (psc_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   psc_q <= '0;
    else if (clr_i) psc_q <= '0;
    else if (en_i)  psc_q <= tick_o ? '0 : psc_q + 1'b1;
  end

  // R9
  psc_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(psc_q));
endmodule

// File: rtl/wdt_arm.sv
module wdt_arm #(
  parameter int ARM_WIN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic use_i,
  output logic arm_o
);
  localparam int AW = $clog2(ARM_WIN + 1);

  logic          arm_q;
  logic [AW-1:0] age_q;

  assign arm_o = arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      age_q <= '0;
    end else if (set_i) begin
      arm_q <= 1'b1;
      age_q <= '0;
    end else if (arm_q) begin
      if (use_i || age_q == AW'(ARM_WIN - 1)) arm_q <= 1'b0;
      age_q <= age_q + 1'b1;
    end
  end

  // R5
  arm_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |-> (age_q < AW'(ARM_WIN)));

  // R5
  arm_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_q) |-> $past(set_i));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int HI_W      = 7,
  parameter int LO_W      = 8,
  parameter int PULSE_CNT = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [HI_W-1:0] reload_i,
  input  logic            tick_i,
  output logic            hit_o,
  output logic            pulse_o
);
  localparam int CW = HI_W + LO_W;
  localparam logic [CW-1:0] TRIG = CW'((1 << CW) - PULSE_CNT);

  logic [HI_W-1:0] hi_q, hi_nx;
  logic [LO_W-1:0] lo_q;
  logic [LO_W:0]   lo_sum;
  logic [CW-1:0]   cnt;

  assign cnt     = {hi_q, lo_q};
  assign lo_sum  = {1'b0, lo_q} + {{LO_W{1'b0}}, 1'b1};
  assign hi_nx   = hi_q + HI_W'(lo_sum[LO_W]);
  assign hit_o   = tick_i && !load_i && ({hi_nx, lo_sum[LO_W-1:0]} == TRIG);
  assign pulse_o = (cnt >= TRIG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= reload_i;
      lo_q <= '0;
    end else if (tick_i) begin
      hi_q <= hi_nx;
      lo_q <= lo_sum[LO_W-1:0];
    end
  end

  // R9
  cnt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt));

  // R7
  trig_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> pulse_o);
endmodule

// File: rtl/watchdog_unit.sv
module watchdog_unit
  import wdt_pkg::*;
#(
  parameter int HI_W      = 7,
  parameter int LO_W      = 8,
  parameter int FAST_DIV  = 2,
  parameter int SLOW_DIV  = 32,
  parameter int ARM_WIN   = 2,
  parameter int PULSE_CNT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_we_i,
  input  logic [HI_W:0]     reload_i,
  input  logic              arm_set_i,
  input  logic              start_set_i,
  input  logic              flag_clr_i,
  input  logic              idle_i,
  input  logic              pdown_i,
  output logic              wdt_rst_o,
  output logic              flag_o,
  output logic              run_o,
  output logic              arm_o
);
  localparam int RW = HI_W + 1;

  logic [RW-1:0] reload_q;
  psc_sel_e      sel_q;
  logic          run_q, flag_q;
  logic          arm, load, freeze, tick, hit, pulse;

  assign freeze    = idle_i | pdown_i;
  assign load      = start_set_i && (!run_q || arm);
  assign wdt_rst_o = pulse;
  assign flag_o    = flag_q;
  assign run_o     = run_q;
  assign arm_o     = arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      sel_q    <= PSC_FAST;
      run_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (reload_we_i) reload_q <= reload_i;
      if (load) sel_q <= psc_sel_e'(reload_q[RW-1]);
      if (start_set_i) run_q <= 1'b1;
      if (hit) flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  wdt_arm #(.ARM_WIN(ARM_WIN)) i_arm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (arm_set_i),
    .use_i (load),
    .arm_o (arm)
  );

  wdt_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) i_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (load),
    .en_i  (run_q && !freeze),
    .sel_i (sel_q),
    .tick_o(tick)
  );

  wdt_counter #(.HI_W(HI_W), .LO_W(LO_W), .PULSE_CNT(PULSE_CNT)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .reload_i(reload_q[HI_W-1:0]),
    .tick_i  (tick),
    .hit_o   (hit),
    .pulse_o (pulse)
  );

  // R3
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);

  // R8
  flag_on_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> flag_o);

  // R1
  rst_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> run_o);
endmodule

// File: tb/test_watchdog_unit.sv
`timescale 1ns/1ps
module test_watchdog_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reload_we_i = 1'b0;
  logic [7:0] reload_i = '0;
  logic       arm_set_i = 1'b0, start_set_i = 1'b0, flag_clr_i = 1'b0;
  logic       idle_i = 1'b0, pdown_i = 1'b0;
  logic       wdt_rst_o, flag_o, run_o, arm_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;
  always_ff @(posedge clk_i) cyc <= cyc + 1;

  watchdog_unit i_watchdog_unit (
    .clk_i, .rst_ni, .reload_we_i, .reload_i, .arm_set_i, .start_set_i,
    .flag_clr_i, .idle_i, .pdown_i, .wdt_rst_o, .flag_o, .run_o, .arm_o
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic ext_reset();
    rst_ni = 1'b0; arm_set_i = 0; start_set_i = 0; flag_clr_i = 0;
    idle_i = 0; pdown_i = 0; reload_we_i = 0;
    tick(1);
    rst_ni = 1'b1;
    tick(1);
  endtask

  task automatic wr_reload(logic [7:0] v);
    reload_we_i = 1; reload_i = v; tick(1); reload_we_i = 0;
  endtask

  task automatic do_start(output int ld);
    start_set_i = 1; ld = cyc + 1; tick(1); start_set_i = 0;
  endtask

  task automatic do_arm();
    arm_set_i = 1; tick(1); arm_set_i = 0;
  endtask

  task automatic wait_rst(output int at);
    int g = 0;
    while (!wdt_rst_o && g < 40000) begin tick(1); g++; end
    at = wdt_rst_o ? cyc : -1;
  endtask

  task automatic pulse_len(output int w);
    int r = cyc;
    int g = 0;
    while (wdt_rst_o && g < 1000) begin tick(1); g++; end
    w = cyc - r;
  endtask

  function automatic int exp_n(int hi, bit slow);
    return (32764 - hi * 256) * (slow ? 32 : 2);
  endfunction

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ld, at, w, s;
    tick(1);
    // R1: reset state
    chk(!run_o && !arm_o && !flag_o && !wdt_rst_o, "R1 reset outputs", {run_o, arm_o, flag_o, wdt_rst_o}, 0);
    rst_ni = 1'b1;
    tick(600);
    chk(!wdt_rst_o && !run_o, "R1 idle without start", wdt_rst_o, 0);

    // R2, R7, R8: fast sweep over reload values
    for (int h = 124; h <= 127; h++) begin
      ext_reset();
      wr_reload(8'(h));
      do_start(ld);
      chk(run_o, "R2 run after start", run_o, 1);
      wait_rst(at);
      chk(at - ld == exp_n(h, 0), "R2 fast timeout", at - ld, exp_n(h, 0));
      chk(flag_o, "R8 flag set", flag_o, 1);
      pulse_len(w);
      chk(w == 8, "R7 fast pulse width", w, 8);
      chk(run_o, "R8 still running", run_o, 1);
    end

    // R2, R7: slow prescaler
    ext_reset();
    wr_reload(8'hFF);
    do_start(ld);
    wait_rst(at);
    chk(at - ld == exp_n(127, 1), "R2 slow timeout", at - ld, exp_n(127, 1));
    pulse_len(w);
    chk(w == 128, "R7 slow pulse width", w, 128);

    // R5: arm self-clears at third edge
    ext_reset();
    arm_set_i = 1; tick(1); arm_set_i = 0;
    chk(arm_o, "R5 arm cycle 1", arm_o, 1);
    tick(1);
    chk(arm_o, "R5 arm cycle 2", arm_o, 1);
    tick(1);
    chk(!arm_o, "R5 arm cleared", arm_o, 0);

    // R4, R5: refresh versus start delay after arming
    for (int d = 1; d <= 4; d++) begin
      ext_reset();
      wr_reload(8'h7F);
      do_start(ld);
      tick(60);
      wr_reload(8'h7E);
      do_arm();
      tick(d - 1);
      do_start(s);
      wait_rst(at);
      if (d <= 2) chk(at - s == exp_n(126, 0), "R4 refresh in window", at - s, exp_n(126, 0));
      else        chk(at - ld == exp_n(127, 0), "R5 late start ignored", at - ld, exp_n(127, 0));
    end

    // R3: start without arm while running is ignored
    ext_reset();
    wr_reload(8'h7F);
    do_start(ld);
    tick(100);
    do_start(s);
    wait_rst(at);
    chk(at - ld == exp_n(127, 0), "R3 unarmed start ignored", at - ld, exp_n(127, 0));
    chk(run_o, "R3 cannot stop", run_o, 1);

    // R6, R8: deferred reload and flag clear
    ext_reset();
    wr_reload(8'h7F);
    do_start(ld);
    tick(50);
    wr_reload(8'hFE);
    wait_rst(at);
    chk(at - ld == exp_n(127, 0), "R6 write deferred", at - ld, exp_n(127, 0));
    pulse_len(w);
    chk(w == 8, "R6 prescaler deferred", w, 8);
    flag_clr_i = 1; tick(1); flag_clr_i = 0;
    chk(!flag_o, "R8 flag cleared", flag_o, 1'b0);
    do_arm();
    do_start(s);
    wait_rst(at);
    chk(at - s == exp_n(126, 1), "R6 applied on refresh", at - s, exp_n(126, 1));
    chk(flag_o, "R8 flag set again", flag_o, 1);
    pulse_len(w);
    chk(w == 128, "R6 slow pulse after refresh", w, 128);

    // R9: idle and power-down freeze
    ext_reset();
    wr_reload(8'h7F);
    do_start(ld);
    tick(30);
    idle_i = 1; tick(77); idle_i = 0;
    tick(20);
    pdown_i = 1; tick(41); pdown_i = 0;
    wait_rst(at);
    chk(at - ld == exp_n(127, 0) + 118, "R9 freeze delays", at - ld, exp_n(127, 0) + 118);

    // R10: external reset after watchdog reset
    chk(flag_o && run_o, "R10 precondition", {flag_o, run_o}, 3);
    rst_ni = 1'b0;
    #1;
    chk(!flag_o && !run_o && !wdt_rst_o, "R10 ext reset clears", {flag_o, run_o, wdt_rst_o}, 0);
    tick(1);
    rst_ni = 1'b1;
    tick(600);
    chk(!wdt_rst_o && !run_o, "R10 stays stopped", {run_o, wdt_rst_o}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule